// File: doc/BRIEF.md
# Write protection control logic

This block decides whether a write to a 256-byte serial memory array may commit, and whether the slave should acknowledge a control byte. Two sources of protection are combined. An external protect pin guards the whole array. A one-time software flag guards only the lower half of the array, addresses 0x00 to 0x7F.

The software flag is set by a write that carries the protection control code instead of the normal array code. After that it can never be cleared. The flag is held in a register that ignores soft reset. A separate power-on load input gives it an initial value, so a bench can model a part that was programmed in an earlier life.

Whether the flag is set is reported on the bus in one way only: whether the protection control code is acknowledged. The bus protocol engine sits outside this block. It supplies the decoded control nibble, the R/W bit, the target address, an array commit strobe and a program strobe. It then uses the registered write-enable and acknowledge-enable outputs.

Top module: `wp_ctrl`

## Requirements
- R1: While `prot_pin` is 1, `wr_en` stays 0 for every address 0x00 to 0xFF, whether the software flag is set or clear.
- R2: With `prot_pin` at 0 and the flag set, an array write is blocked when address bit 7 is 0 (0x00 to 0x7F). It is allowed when address bit 7 is 1 (0x80 to 0xFF).
- R3: With `prot_pin` at 0 and the flag clear, an array write to any address is allowed. An array write is a commit strobe with control code 4'b1010 and `rw_read` at 0.
- R4: The flag becomes 1 at the clock edge that samples all of the following together: `prog_strobe` at 1, control code 4'b0110, `rw_read` at 0, `prot_pin` at 0 and the flag clear. Address and data are ignored for this.
- R5: Once set, the flag is never cleared, by any command or by soft reset. Only a power-on load (`por_n` at 0) writes it, and the value written is `por_flag_init`.
- R6: While the flag is set, control code 4'b0110 is not acknowledged (`ack_en` at 0), with `rw_read` either 0 or 1.
- R7: While `prot_pin` is 1 and the flag is clear, a 4'b0110 write is acknowledged. A program strobe in that state leaves the flag clear.
- R8: A 4'b0110 read with the flag clear is acknowledged. A program strobe given with `rw_read` at 1 leaves the flag clear.
- R9: Control code 4'b1010 is always acknowledged, even when the write it carries is blocked. Any other code is never acknowledged.
- R10: `wr_en` and `ack_en` are registered, one clock after their inputs. A synchronous soft reset (`rst_n` at 0) drives both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset; has no effect on the flag |
| por_n | input | 1 | Synchronous active-low power-on load of the flag |
| por_flag_init | input | 1 | Flag value loaded during power-on |
| prot_pin | input | 1 | Hardware protect pin, 1 = whole array protected |
| ctl_code | input | 4 | Control nibble of the device address byte |
| rw_read | input | 1 | R/W bit, 1 = read |
| tgt_addr | input | 8 | Array address of the write |
| commit_req | input | 1 | Request to commit an array write |
| prog_strobe | input | 1 | Request to program the protection flag |
| wr_en | output | 1 | Array write may commit (registered) |
| ack_en | output | 1 | Acknowledge the control byte (registered) |
| sw_flag | output | 1 | Current software protection flag |

## Verification
The bench drives all inputs on the falling edge. `wr_en` and `ack_en` are registered, so they answer at the next rising edge and are sampled on the falling edge that follows, one full cycle after the stimulus. The flag also updates on that same rising edge, so it is read at the same falling edge. The next stimulus therefore meets the new flag value. Every scenario task keeps one stimulus per cycle and checks that cycle's outputs before it drives the next value.

// File: rtl/wp_pkg.sv
// Shared types for the write protection control logic.
package wp_pkg;
    // Class of the control nibble seen on the bus.
    typedef enum logic [1:0] {
        CC_NONE  = 2'd0,
        CC_ARRAY = 2'd1,
        CC_PROT  = 2'd2
    } code_class_e;
endpackage

// File: rtl/wp_code_decode.sv
// Classifies the control nibble as an array access, a protection-flag
// access or a foreign code. Pure combinational; assumes the nibble is
// stable while it is sampled.
module wp_code_decode
    import wp_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
    parameter logic [CODE_W-1:0] PROT_CODE  = 4'b0110
) (
    input  logic [CODE_W-1:0] code_i,
    output code_class_e       class_o
);
    // Map the nibble onto its class.
    always_comb begin
        if (code_i == ARRAY_CODE)     class_o = CC_ARRAY;
        else if (code_i == PROT_CODE) class_o = CC_PROT;
        else                          class_o = CC_NONE;
    end
endmodule

// File: rtl/wp_sticky_flag.sv
// One-time software protection flag. Only a power-on load writes
// it freely; otherwise it can only go from 0 to 1. Soft reset is not
// an input on purpose. Assumes por_n is held low for at least one edge
// at power-up.
module wp_sticky_flag (
    input  logic clk,
    input  logic por_n,
    input  logic por_init_i,
    input  logic set_i,
    output logic flag_o
);
    // Load on power-on, otherwise set-only.
    always_ff @(posedge clk) begin
        if (!por_n)     flag_o <= por_init_i;
        else if (set_i) flag_o <= 1'b1;
    end

    // R5: once set, the flag stays set outside a power-on load.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        flag_o |=> flag_o);
endmodule

// File: rtl/wp_array_guard.sv
// Decides whether an array address is writable from the pin and flag.
// The lower half is the range whose address MSB is 0.
module wp_array_guard #(
    parameter int ADDR_W = 8
) (
    input  logic              pin_i,
    input  logic              flag_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              allow_o
);
    localparam int MSB = ADDR_W - 1;

    // The pin blocks everything; the flag blocks the lower half only.
    always_comb begin
        if (pin_i)                      allow_o = 1'b0;
        else if (flag_i && !addr_i[MSB]) allow_o = 1'b0;
        else                            allow_o = 1'b1;
    end
endmodule

// File: rtl/wp_ctrl.sv
// Write protection control: combines the hardware protect pin and the
// one-time software flag into a registered write enable and acknowledge
// enable. Assumes the protocol engine presents code, R/W and address
// together with the commit or program strobe for one cycle.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
    parameter logic [CODE_W-1:0] PROT_CODE  = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              por_flag_init,
    input  logic              prot_pin,
    input  logic [CODE_W-1:0] ctl_code,
    input  logic              rw_read,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              commit_req,
    input  logic              prog_strobe,
    output logic              wr_en,
    output logic              ack_en,
    output logic              sw_flag
);
    code_class_e cls;
    logic        addr_ok;
    logic        flag_set;
    logic        ack_next;
    logic        wr_next;

    wp_code_decode #(
        .CODE_W(CODE_W), .ARRAY_CODE(ARRAY_CODE), .PROT_CODE(PROT_CODE)
    ) u_dec (
        .code_i(ctl_code), .class_o(cls)
    );

    wp_array_guard #(.ADDR_W(ADDR_W)) u_guard (
        .pin_i(prot_pin), .flag_i(sw_flag), .addr_i(tgt_addr), .allow_o(addr_ok)
    );

    wp_sticky_flag u_flag (
        .clk(clk), .por_n(por_n), .por_init_i(por_flag_init),
        .set_i(flag_set), .flag_o(sw_flag)
    );

    // Qualify the program request: write form, pin low, flag still clear.
    assign flag_set = prog_strobe && (cls == CC_PROT) && !rw_read
                      && !prot_pin && !sw_flag;

    // Next acknowledge and write-enable decisions.
    always_comb begin
        case (cls)
            CC_ARRAY: ack_next = 1'b1;
            CC_PROT:  ack_next = !sw_flag;
            default:  ack_next = 1'b0;
        endcase
        wr_next = commit_req && (cls == CC_ARRAY) && !rw_read && addr_ok;
    end

    // Register the decisions; soft reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            ack_en <= 1'b0;
        end else begin
            wr_en  <= wr_next;
            ack_en <= ack_next;
        end
    end

    // R1: the pin blocks every array write.
    a_r1_pin_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        prot_pin |=> !wr_en);
    // R2: with the flag set the lower half is never written.
    a_r2_lower_half_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_flag && !tgt_addr[ADDR_W-1]) |=> !wr_en);
    // R6: protection code is refused while the flag is set.
    a_r6_no_ack_when_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_flag && ctl_code == PROT_CODE) |=> !ack_en);
    // R9: array code is always acknowledged.
    a_r9_array_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_code == ARRAY_CODE) |=> ack_en);
    // R7: the flag only rises from a program strobe with the pin low.
    a_r7_pin_blocks_prog: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(sw_flag) && $past(por_n)) |-> $past(!prot_pin && prog_strobe));
endmodule

// File: tb/wp_ctrl_tb.sv
module wp_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, por_n, por_flag_init, prot_pin;
    logic [3:0] ctl_code;
    logic       rw_read;
    logic [7:0] tgt_addr;
    logic       commit_req, prog_strobe;
    logic       wr_en, ack_en, sw_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [3:0] ARR  = 4'b1010;
    localparam logic [3:0] PROT = 4'b0110;

    always #5 clk = ~clk;

    wp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .por_flag_init(por_flag_init),
        .prot_pin(prot_pin), .ctl_code(ctl_code), .rw_read(rw_read),
        .tgt_addr(tgt_addr), .commit_req(commit_req), .prog_strobe(prog_strobe),
        .wr_en(wr_en), .ack_en(ack_en), .sw_flag(sw_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus on the falling edge, then wait to the next falling edge.
    task automatic step(input logic pin, input logic [3:0] code, input logic rd,
                        input logic [7:0] a, input logic cm, input logic pg);
        @(negedge clk);
        prot_pin = pin; ctl_code = code; rw_read = rd; tgt_addr = a;
        commit_req = cm; prog_strobe = pg;
        @(negedge clk);
        commit_req = 1'b0; prog_strobe = 1'b0;
    endtask

    task automatic power_on(input logic init);
        @(negedge clk);
        por_n = 1'b0; rst_n = 1'b0; por_flag_init = init;
        @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        chk("R10 reset wr_en", wr_en, 1'b0);
        chk("R10 reset ack_en", ack_en, 1'b0);
        chk("R5 por load 0", sw_flag, 1'b0);
    endtask

    task automatic t_open_array;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] a;
            a = (i == 0) ? 8'h00 : (i == 1) ? 8'h7F : (i == 2) ? 8'h80 : 8'hFF;
            step(1'b0, ARR, 1'b0, a, 1'b1, 1'b0);
            chk("R3 open write", wr_en, 1'b1);
            chk("R9 array ack", ack_en, 1'b1);
        end
        step(1'b0, ARR, 1'b0, 8'h10, 1'b0, 1'b0);
        chk("R10 no commit no wr", wr_en, 1'b0);
    endtask

    task automatic t_pin_blocks(input logic flag_exp);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, ARR, 1'b0, (i == 0) ? 8'h00 : (i == 1) ? 8'h7F : 8'hFF, 1'b1, 1'b0);
            chk("R1 pin blocks", wr_en, 1'b0);
            chk("R9 blocked still acked", ack_en, 1'b1);
        end
        chk("R1 flag unchanged", sw_flag, flag_exp);
    endtask

    task automatic t_other_code;
        step(1'b0, 4'b0000, 1'b0, 8'h80, 1'b1, 1'b0);
        chk("R9 foreign code no ack", ack_en, 1'b0);
        chk("R9 foreign code no wr", wr_en, 1'b0);
    endtask

    task automatic t_prot_read_clear;
        step(1'b0, PROT, 1'b1, 8'h00, 1'b0, 1'b0);
        chk("R8 read ack when clear", ack_en, 1'b1);
        step(1'b0, PROT, 1'b1, 8'h00, 1'b0, 1'b1);
        chk("R8 read does not program", sw_flag, 1'b0);
    endtask

    task automatic t_prog_with_pin;
        step(1'b1, PROT, 1'b0, 8'h55, 1'b0, 1'b1);
        chk("R7 pin-high prot write acked", ack_en, 1'b1);
        chk("R7 pin-high no program", sw_flag, 1'b0);
    endtask

    task automatic t_program;
        step(1'b0, PROT, 1'b0, 8'hA3, 1'b0, 1'b1);
        chk("R4 flag programmed", sw_flag, 1'b1);
        chk("R4 program cycle acked", ack_en, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R5 soft reset keeps flag", sw_flag, 1'b1);
        chk("R10 soft reset clears ack", ack_en, 1'b0);
    endtask

    task automatic t_flag_set;
        step(1'b0, PROT, 1'b1, 8'h00, 1'b0, 1'b0);
        chk("R6 no ack read", ack_en, 1'b0);
        step(1'b0, PROT, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 no ack write", ack_en, 1'b0);
        chk("R5 still set", sw_flag, 1'b1);
        step(1'b0, ARR, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R2 0x00 blocked", wr_en, 1'b0);
        step(1'b0, ARR, 1'b0, 8'h7F, 1'b1, 1'b0);
        chk("R2 0x7F blocked", wr_en, 1'b0);
        chk("R9 blocked acked", ack_en, 1'b1);
        step(1'b0, ARR, 1'b0, 8'h80, 1'b1, 1'b0);
        chk("R2 0x80 allowed", wr_en, 1'b1);
        step(1'b0, ARR, 1'b0, 8'hFF, 1'b1, 1'b0);
        chk("R2 0xFF allowed", wr_en, 1'b1);
    endtask

    task automatic t_power_cycle;
        power_on(1'b1);
        chk("R5 por keeps programmed", sw_flag, 1'b1);
        step(1'b0, ARR, 1'b0, 8'h20, 1'b1, 1'b0);
        chk("R2 lower locked after por", wr_en, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; por_n = 1'b0; por_flag_init = 1'b0; prot_pin = 1'b0;
        ctl_code = 4'h0; rw_read = 1'b0; tgt_addr = 8'h00;
        commit_req = 1'b0; prog_strobe = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        t_reset_state();
        t_open_array();
        t_pin_blocks(1'b0);
        t_other_code();
        t_prot_read_clear();
        t_prog_with_pin();
        t_program();
        t_flag_set();
        t_pin_blocks(1'b1);
        t_power_cycle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule